// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Pin Override

This block is an 8-bit general-purpose I/O port with a small register interface. Software reaches three registers through it: a data register, a read-only register that mirrors the pins, and a direction register. Only pins 2 to 5 exist. The other four bit positions are absent from every register and are never driven onto a pad.

Two CAN controller channels, each with its own enable input, can take over a fixed pair of pins for their transmit and receive lines. While a channel is enabled it owns its pair outright, and the GPIO data and direction settings for those pins have no effect on the pads. Pad levels pass through a two-stage synchronizer before any register read can see them. The receive line of each channel comes directly from its pad.

Top module: `can_shared_port`

## Requirements
- R1: While reset is asserted, every pad output enable is 0, whatever the channel enables are. After reset, with both channels disabled, every output enable stays 0 until the direction register is written.
- R2: On a GPIO-owned pin whose direction bit is 1, pad_oe is 1 and pad_out carries the stored data bit. On a GPIO-owned pin whose direction bit is 0, pad_oe is 0.
- R3: A read at address 0 returns, for each implemented bit, the stored data bit when its direction bit is 1, and the synchronized pin level when its direction bit is 0.
- R4: A read at address 1 returns the implemented pin levels. A pad change becomes visible after two rising clock edges.
- R5: A write to address 1 has no effect: the data and direction registers read back unchanged afterwards.
- R6: Bits 7, 6, 1 and 0 read as 0 at addresses 0, 1 and 2, and the pads at those positions are never driven.
- R7: The direction register at address 2 can be read and written. Its implemented bits (mask 0x3C) reset to 0, and a 1 selects output.
- R8: While ch1_en is 1, pin 5 has pad_oe=1 and pad_out=ch1_tx, pin 4 has pad_oe=0, and ch1_rx follows pad_in[4] in the same cycle, whatever the GPIO settings are.
- R9: While ch0_en is 1, pin 3 has pad_oe=1 and pad_out=ch0_tx, pin 2 has pad_oe=0, and ch0_rx follows pad_in[2] in the same cycle, whatever the GPIO settings are.
- R10: A disabled channel presents its receive line at the recessive level 1.
- R11: Reset leaves data register bits 5 to 2 unchanged. A value written before a reset pulse reads back after it once the direction bits are set to 1.
- R12: bus_rdata is 0 when bus_re is 0 or when the address is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 pin levels, 2 direction |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from registered state |
| pad_in | input | 8 | Levels seen at the pads |
| pad_out | output | 8 | Values driven to the pads |
| pad_oe | output | 8 | Pad output enables, 1 drives |
| ch0_en | input | 1 | Channel 0 enable |
| ch0_tx | input | 1 | Channel 0 transmit line |
| ch0_rx | output | 1 | Channel 0 receive line |
| ch1_en | input | 1 | Channel 1 enable |
| ch1_tx | input | 1 | Channel 1 transmit line |
| ch1_rx | output | 1 | Channel 1 receive line |

## Verification
The case that is hardest to reach from the ports is the data register holding its contents through a reset. The register has no reset value, and straight after a reset the direction bits are 0, so a read at address 0 shows the pins and not the stored bits. To reach it, the stimulus writes a known pattern, pulses reset, programs every direction bit to output, and only then reads address 0. A second difficulty is the mixed-direction read. Pads are chosen whose levels differ from the stored bits, and the read is delayed until the two synchronizer edges have passed, so that each bit shows which source it came from.

// File: rtl/can_shared_port_pkg.sv
package can_shared_port_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int NUM_CH   = 2;
  localparam logic [PORT_W-1:0] IMPL_MASK = 8'h3C;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_PINS = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIR  = 2'd2;

  typedef enum logic [2:0] {
    ROLE_NONE, ROLE_GPIO, ROLE_TX, ROLE_RX
  } pin_role_e;

  function automatic int tx_pin(input int ch);
    return (ch == 0) ? 3 : 5;
  endfunction

  function automatic int rx_pin(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

  function automatic pin_role_e pin_role(input int p);
    pin_role_e r;
    r = IMPL_MASK[p] ? ROLE_GPIO : ROLE_NONE;
    for (int c = 0; c < NUM_CH; c++) begin
      if (tx_pin(c) == p) r = ROLE_TX;
      if (rx_pin(c) == p) r = ROLE_RX;
    end
    return r;
  endfunction

  function automatic int pin_channel(input int p);
    int ch;
    ch = 0;
    for (int c = 0; c < NUM_CH; c++)
      if (tx_pin(c) == p || rx_pin(c) == p) ch = c;
    return ch;
  endfunction

  function automatic logic [PORT_W-1:0] data_view(
      input logic [PORT_W-1:0] dir, input logic [PORT_W-1:0] stored,
      input logic [PORT_W-1:0] pins);
    return ((dir & stored) | (~dir & pins)) & IMPL_MASK;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/port_regs.sv
module port_regs
  import can_shared_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pins_sync,
  output logic [PORT_W-1:0] rdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] dir_q
);
  logic wr_data, wr_dir, wr_ignored;
  assign wr_data    = we && (addr == A_DATA);
  assign wr_dir     = we && (addr == A_DIR);
  assign wr_ignored = we && (addr == A_PINS);

  // data register bits keep their value across reset
  always_ff @(posedge clk) begin
    if (wr_data) data_q <= wdata & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata & IMPL_MASK;
  end

  always_comb begin
    rdata = '0;
    if (re) begin
      unique case (addr)
        A_DATA:  rdata = data_view(dir_q, data_q, pins_sync);
        A_PINS:  rdata = pins_sync & IMPL_MASK;
        A_DIR:   rdata = dir_q;
        default: rdata = '0;
      endcase
    end
  end

  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> $stable(dir_q) && $stable(data_q));

  // R7
  dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import can_shared_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_tx,
  output logic [NUM_CH-1:0] ch_rx,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pin_owned
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam pin_role_e ROLE = pin_role(i);
    localparam int        CH   = pin_channel(i);
    if (ROLE == ROLE_NONE) begin : g_absent
      assign pin_owned[i] = 1'b0;
      assign pad_out[i]   = 1'b0;
      assign pad_oe[i]    = 1'b0;
    end else if (ROLE == ROLE_TX) begin : g_tx
      assign pin_owned[i] = ch_en[CH];
      assign pad_out[i]   = pin_owned[i] ? ch_tx[CH] : data_q[i];
      assign pad_oe[i]    = rst_n && (pin_owned[i] || dir_q[i]);
    end else if (ROLE == ROLE_RX) begin : g_rx
      assign pin_owned[i] = ch_en[CH];
      assign pad_out[i]   = pin_owned[i] ? 1'b0 : data_q[i];
      assign pad_oe[i]    = rst_n && !pin_owned[i] && dir_q[i];
    end else begin : g_gpio
      assign pin_owned[i] = 1'b0;
      assign pad_out[i]   = data_q[i];
      assign pad_oe[i]    = rst_n && dir_q[i];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_rx[c] = ch_en[c] ? pad_in[rx_pin(c)] : 1'b1;

    // R8 R9
    tx_owns_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en[c] |-> pad_oe[tx_pin(c)] && (pad_out[tx_pin(c)] == ch_tx[c]));
    // R8 R9
    rx_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en[c] |-> !pad_oe[rx_pin(c)]);
    // R10
    rx_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |-> ch_rx[c]);
  end
endmodule

// File: rtl/can_shared_port.sv
module can_shared_port
  import can_shared_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  input  logic              ch0_en,
  input  logic              ch0_tx,
  output logic              ch0_rx,
  input  logic              ch1_en,
  input  logic              ch1_tx,
  output logic              ch1_rx
);
  logic [PORT_W-1:0] pins_sync;
  logic [PORT_W-1:0] data_q, dir_q, pin_owned;
  logic [NUM_CH-1:0] ch_rx;

  pin_sync #(.W(PORT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync)
  );

  port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
    .wdata(bus_wdata), .pins_sync(pins_sync), .rdata(bus_rdata),
    .data_q(data_q), .dir_q(dir_q)
  );

  pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .data_q(data_q), .dir_q(dir_q), .pad_in(pad_in),
    .ch_en({ch1_en, ch0_en}), .ch_tx({ch1_tx, ch0_tx}), .ch_rx(ch_rx),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_owned(pin_owned)
  );

  assign ch0_rx = ch_rx[0];
  assign ch1_rx = ch_rx[1];

  // cycles since reset release, saturating, for the latency check
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  // R1
  reset_hiz_chk: assert property (@(posedge clk) !rst_n |-> pad_oe == '0);
  // R6
  absent_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~IMPL_MASK) == '0) && ((pad_oe & ~IMPL_MASK) == '0));
  // R4
  pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) && bus_re && (bus_addr == A_PINS)
      |-> bus_rdata == ($past(pad_in, 2) & IMPL_MASK));
  // R12
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == '0);
  // R2
  owned_not_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_owned == '0) |-> pad_oe == dir_q);
endmodule

// File: tb/can_shared_port_test.sv
module can_shared_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_wdata = '0, pad_in = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic       ch0_en = 1'b0, ch0_tx = 1'b1, ch1_en = 1'b0, ch1_tx = 1'b1;
  logic       ch0_rx, ch1_rx;

  int total = 0;
  int fails = 0;

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  can_shared_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ch0_en(ch0_en), .ch0_tx(ch0_tx), .ch0_rx(ch0_rx),
    .ch1_en(ch1_en), .ch1_tx(ch1_tx), .ch1_rx(ch1_rx)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when a read is on the bus
  initial forever begin
    @(negedge clk); #3;
    if (bus_re) begin
      if (sb.size() == 0) check("scoreboard-empty", bus_rdata, 8'h00);
      else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    sb.push_back('{tag, exp});
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #3;
  endtask

  task automatic set_pads(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset holds pads undriven even with a channel enabled
    ch1_en = 1'b1;
    repeat (3) @(negedge clk);
    #3 check("R1 oe during reset", pad_oe, 8'h00);
    ch1_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    settle();
    check("R1 oe after reset", pad_oe, 8'h00);
    check("R10 ch0_rx idle", {7'd0, ch0_rx}, 8'h01);
    check("R10 ch1_rx idle", {7'd0, ch1_rx}, 8'h01);
    rd(2'd2, 8'h00, "R7 dir reset value");
    check("R12 idle read", bus_rdata, 8'h00);

    // pins visible through input and data registers
    set_pads(8'hA5);
    rd(2'd1, 8'h24, "R4 R6 pin levels");
    rd(2'd0, 8'h24, "R3 data reads pins when input");

    // outputs
    wr(2'd0, 8'hDB);
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h3C, "R7 R6 dir readback");
    rd(2'd0, 8'h18, "R3 data reads stored when output");
    settle();
    check("R2 oe all outputs", pad_oe, 8'h3C);
    check("R2 pad_out", pad_out & 8'h3C, 8'h18);

    // mixed direction
    wr(2'd2, 8'h0C);
    set_pads(8'h30);
    rd(2'd0, 8'h38, "R3 mixed direction");
    rd(2'd1, 8'h30, "R4 pins again");
    settle();
    check("R2 oe mixed", pad_oe, 8'h0C);

    // R5: write to pin register ignored
    wr(2'd1, 8'hFF);
    rd(2'd2, 8'h0C, "R5 dir unchanged");
    rd(2'd0, 8'h38, "R5 data unchanged");
    rd(2'd12 & 2'd3, 8'h38, "R5 data unchanged again");

    // channel 1 takes pins 5 and 4
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'h00);
    @(negedge clk); ch1_en = 1'b1; ch1_tx = 1'b0; pad_in = 8'h00;
    settle();
    check("R8 oe tx on, rx off", pad_oe, 8'h2C);
    check("R8 tx low", pad_out & 8'h20, 8'h00);
    check("R8 rx follows pad low", {7'd0, ch1_rx}, 8'h00);
    check("R10 ch0 still idle", {7'd0, ch0_rx}, 8'h01);
    @(negedge clk); ch1_tx = 1'b1; pad_in = 8'h10;
    #3;
    check("R8 tx high", pad_out & 8'h20, 8'h20);
    check("R8 rx follows pad high", {7'd0, ch1_rx}, 8'h01);

    // channel 0 takes pins 3 and 2; channel 1 released
    @(negedge clk); ch1_en = 1'b0; ch0_en = 1'b1; ch0_tx = 1'b1; pad_in = 8'h00;
    settle();
    check("R9 oe", pad_oe, 8'h38);
    check("R9 tx high", pad_out & 8'h08, 8'h08);
    check("R9 rx low", {7'd0, ch0_rx}, 8'h00);
    check("R10 ch1 released", {7'd0, ch1_rx}, 8'h01);
    check("R2 pin5 back to gpio", pad_out & 8'h20, 8'h00);
    @(negedge clk); ch0_tx = 1'b0; pad_in = 8'h04;
    #3;
    check("R9 tx low", pad_out & 8'h08, 8'h00);
    check("R9 rx high", {7'd0, ch0_rx}, 8'h01);
    @(negedge clk); ch0_en = 1'b0;

    // R11: data survives a reset pulse
    wr(2'd0, 8'h14);
    @(negedge clk); rst_n = 1'b0;
    settle();
    check("R1 oe in second reset", pad_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd2, 8'h00, "R7 dir cleared by reset");
    wr(2'd2, 8'h3C);
    rd(2'd0, 8'h14, "R11 data kept through reset");

    // R12: unused address
    rd(2'd3, 8'h00, "R12 address 3");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) check("scoreboard-leftover", 8'(sb.size()), 8'h00);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule